// File: doc/BRIEF.md
# Glitch-free power-of-two clock prescaler

This block slows a fast source clock by a run-time selectable power of two. The result feeds the CPU and every synchronous peripheral domain together, so all of them slow by the same factor. A free-running counter on the undivided source clock marks the period boundaries. The block produces two outputs from it. One is a clock-enable pulse, `sys_ce`, which is high for one source cycle per divided period. The other is a gated clock, `sys_clk`, which has one high phase per divided period. With divide by 1 the enable stays high and the gated clock equals the source clock.

A write strobe loads a new division code as a pending target. The target takes effect only on a source cycle that ends a period under both the old and the new division, which means a boundary of the longer period. As a result, no interval between enable pulses is ever shorter than the smaller of the two periods, and the gated clock never has a runt pulse. The wait before a new division takes effect depends on the counter phase at the time of the write, so it is not fixed.

An enable input can mirror the divided clock onto a clock-output pin and override that pin's normal function. This works during reset as well.

Top module: `sysclk_prescaler`

## Requirements
- R1: A synchronous reset selects divide by 1 and clears the counter. From the first cycle after reset, `sys_ce` is high on every source cycle.
- R2: A code k from 0 to 8 selects divide by 2^k. Once it is in force, `sys_ce` is high for exactly one source cycle in every 2^k cycles.
- R3: Codes 9 to 15 select divide by 256.
- R4: A new division takes effect only on a cycle where `sys_ce` is high under both the old and the new setting. Each interval between consecutive `sys_ce` pulses equals the division that is in force at the pulse that ends it. No interval is shorter than the smaller of the old and new periods.
- R5: `sys_clk` is low during every low phase of the source clock. During a high phase, `sys_clk` equals the `sys_ce` value that was present in the preceding low phase, so it has no partial pulses.
- R6: A write made while an earlier target is still pending replaces that target. Only the last code written ever takes effect.
- R7: When `clkout_en` is 1, `clkout_ovr` is 1 and `clkout_pin` carries `sys_clk`. When `clkout_en` is 0, both are 0.
- R8: While reset is held, `clkout_pin` still carries the clock, which runs at divide by 1.
- R9: Writing the code that is already in force leaves the pulse period unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Undivided source clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr | input | 1 | Strobe that loads `sel_code` as the pending division |
| sel_code | input | SEL_W (4) | Division code k, meaning divide by 2^k; values above 8 clamp to 8 |
| clkout_en | input | 1 | Mirrors the divided clock onto the output pin |
| sys_ce | output | 1 | One-cycle enable per divided period |
| sys_clk | output | 1 | Gated divided clock |
| clkout_pin | output | 1 | Clock-output pin value |
| clkout_ovr | output | 1 | High when the pin's normal function is overridden |

## Verification
Each legal code is held in turn, which separates correct period lengths from off-by-one or wrong-bit errors in the boundary detect. The clamped codes 9 and 15 are exercised separately. Directed switches exercise three cases: a back-to-back overwrite of a pending target, a rewrite of the code already in force, and moves up and down from divide by 256. Together these distinguish an applied-at-boundary switch from an immediate or a stale one. Long runs of random codes and hold times, with the pin enable also varied, compare every pulse and every gated-clock phase with a behavioural model, and measure each pulse interval against the division in force at the pulse that ends it.

// File: rtl/sysclk_prescaler_pkg.sv
package sysclk_prescaler_pkg;

    // Clamp a requested division exponent to the largest supported one.
    function automatic int unsigned clamp_log(input int unsigned code,
                                              input int unsigned lmax);
        return (code > lmax) ? lmax : code;
    endfunction

    // True when the low 'lg' bits of the counter are all ones, i.e. the
    // current source cycle is the last one of a 2**lg period.
    function automatic logic at_boundary(input logic [31:0] cnt,
                                         input int unsigned lg);
        for (int i = 0; i < 32; i++) begin
            if (i < int'(lg) && !cnt[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    typedef enum logic {
        RATE_HOLD = 1'b0,
        RATE_SWAP = 1'b1
    } rate_action_e;

endpackage

// File: rtl/prescale_counter.sv
module prescale_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/boundary_detect.sv
module boundary_detect
    import sysclk_prescaler_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int LOG_W = 4
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [LOG_W-1:0] log_sel,
    output logic             hit
);
    always_comb begin
        hit = at_boundary(32'(cnt), 32'(log_sel));
    end
endmodule

// File: rtl/rate_switch.sv
module rate_switch
    import sysclk_prescaler_pkg::*;
#(
    parameter int SEL_W   = 4,
    parameter int LOG_MAX = 8,
    parameter int LOG_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_code,
    input  logic             hit_act,
    input  logic             hit_pend,
    output logic [LOG_W-1:0] act_log,
    output logic [LOG_W-1:0] pend_log
);
    logic [LOG_W-1:0] act_q, pend_q;
    rate_action_e     action;

    always_comb begin
        action = (pend_q != act_q && hit_act && hit_pend) ? RATE_SWAP : RATE_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            pend_q <= '0;
        end else begin
            if (action == RATE_SWAP) act_q <= pend_q;
            if (sel_wr) pend_q <= LOG_W'(clamp_log(32'(sel_code), LOG_MAX));
        end
    end

    assign act_log  = act_q;
    assign pend_log = pend_q;
endmodule

// File: rtl/clock_gate.sv
module clock_gate (
    input  logic clk,
    input  logic ce,
    input  logic out_en,
    output logic gclk,
    output logic pin,
    output logic ovr
);
    logic en_lat;

    // Transparent only while the source clock is low, so the enable
    // cannot change during a high phase.
    always_latch begin
        if (!clk) en_lat <= ce;
    end

    assign gclk = clk & en_lat;
    assign pin  = out_en ? gclk : 1'b0;
    assign ovr  = out_en;
endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler #(
    parameter int SEL_W   = 4,
    parameter int LOG_MAX = 8
) (
    input  logic             src_clk,
    input  logic             rst,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_code,
    input  logic             clkout_en,
    output logic             sys_ce,
    output logic             sys_clk,
    output logic             clkout_pin,
    output logic             clkout_ovr
);
    localparam int CNT_W = (LOG_MAX > 0) ? LOG_MAX : 1;
    localparam int LOG_W = $clog2(LOG_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic [LOG_W-1:0] act_log, pend_log;
    logic [LOG_W-1:0] sel_log [2];
    logic             hit     [2];

    assign sel_log[0] = act_log;
    assign sel_log[1] = pend_log;

    prescale_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk (src_clk),
        .rst (rst),
        .cnt (cnt)
    );

    for (genvar g = 0; g < 2; g++) begin : g_detect
        boundary_detect #(.CNT_W(CNT_W), .LOG_W(LOG_W)) u_det (
            .cnt     (cnt),
            .log_sel (sel_log[g]),
            .hit     (hit[g])
        );
    end

    rate_switch #(.SEL_W(SEL_W), .LOG_MAX(LOG_MAX), .LOG_W(LOG_W)) u_rate (
        .clk      (src_clk),
        .rst      (rst),
        .sel_wr   (sel_wr),
        .sel_code (sel_code),
        .hit_act  (hit[0]),
        .hit_pend (hit[1]),
        .act_log  (act_log),
        .pend_log (pend_log)
    );

    assign sys_ce = hit[0];

    clock_gate u_gate (
        .clk    (src_clk),
        .ce     (sys_ce),
        .out_en (clkout_en),
        .gclk   (sys_clk),
        .pin    (clkout_pin),
        .ovr    (clkout_ovr)
    );
endmodule

// File: rtl/sysclk_prescaler_chk.sv
module sysclk_prescaler_chk #(
    parameter int LOG_MAX = 8,
    parameter int LOG_W   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             sys_ce,
    input logic [LOG_W-1:0] act_log,
    input logic             clkout_en,
    input logic             clkout_pin,
    input logic             clkout_ovr
);
    logic [LOG_MAX+1:0] gap_q;
    int unsigned        prev_n_q;
    int unsigned        cur_n, min_n;

    always_comb begin
        cur_n = 32'd1 << act_log;
        min_n = (prev_n_q < cur_n) ? prev_n_q : cur_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q    <= '0;
            prev_n_q <= 32'd1;
        end else if (sys_ce) begin
            gap_q    <= '0;
            prev_n_q <= cur_n;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    p_div1_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> sys_ce);

    p_code_clamped_r3: assert property (@(posedge clk) disable iff (rst)
        int'(act_log) <= LOG_MAX);

    p_swap_on_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_log) |-> $past(sys_ce));

    p_no_short_gap_r4: assert property (@(posedge clk) disable iff (rst)
        sys_ce |-> (int'(gap_q) + 1 >= int'(min_n)));

    p_pin_follow_r7: assert property (@(posedge clk) disable iff (rst)
        (clkout_ovr == clkout_en) && (clkout_en || !clkout_pin));
endmodule

bind sysclk_prescaler sysclk_prescaler_chk #(.LOG_MAX(LOG_MAX), .LOG_W(LOG_W)) u_chk (
    .clk        (src_clk),
    .rst        (rst),
    .sys_ce     (sys_ce),
    .act_log    (act_log),
    .clkout_en  (clkout_en),
    .clkout_pin (clkout_pin),
    .clkout_ovr (clkout_ovr)
);

// File: tb/sysclk_prescaler_test.sv
`timescale 1ns/1ps
module sysclk_prescaler_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_wr = 1'b0;
    logic [3:0] sel_code = 4'd0;
    logic       clkout_en = 1'b1;
    logic       sys_ce, sys_clk, clkout_pin, clkout_ovr;

    always #2 clk = ~clk;

    sysclk_prescaler uut (
        .src_clk    (clk),
        .rst        (rst),
        .sel_wr     (sel_wr),
        .sel_code   (sel_code),
        .clkout_en  (clkout_en),
        .sys_ce     (sys_ce),
        .sys_clk    (sys_clk),
        .clkout_pin (clkout_pin),
        .clkout_ovr (clkout_ovr)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    string req_tag  = "R8";

    // Behavioural reference state.
    int m_cnt = 0, m_act = 0, m_pend = 0;
    bit m_valid = 0;
    int gap = 0;
    bit gap_ok = 0;

    task automatic check(input bit ok, input string req, input int got,
                         input int exp, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    function automatic int clampk(input int c);
        return (c > 8) ? 8 : c;
    endfunction

    function automatic bit m_hit(input int k);
        return ((m_cnt + 1) % (1 << k)) == 0;
    endfunction

    task automatic step(input bit r, input bit w, input int c, input bit e);
        bit exp_ce;
        bit was_valid;
        int exp_pin;
        exp_ce = 1'b0;
        @(negedge clk);
        #1;
        was_valid = m_valid;
        if (m_valid) begin
            exp_ce = m_hit(m_act);
            check(sys_ce == exp_ce, req_tag, int'(sys_ce), int'(exp_ce), "clock enable");
            check(sys_clk == 1'b0, "R5", int'(sys_clk), 0, "gated clock in low phase");
            if (!rst) begin
                if (sys_ce) begin
                    // R4: interval equals the division in force at its closing pulse
                    if (gap_ok)
                        check(gap + 1 == (1 << m_act), "R4", gap + 1, 1 << m_act, "pulse interval");
                    gap    = 0;
                    gap_ok = 1;
                end else begin
                    gap++;
                end
            end
        end
        rst       = r;
        sel_wr    = w;
        sel_code  = 4'(c);
        clkout_en = e;
        @(posedge clk);
        if (r) begin
            m_cnt = 0; m_act = 0; m_pend = 0; m_valid = 1;
            gap = 0; gap_ok = 0;
        end else begin
            int nact;
            nact = m_act;
            if (m_pend != m_act && m_hit(m_act) && m_hit(m_pend)) nact = m_pend;
            if (w) m_pend = clampk(c);
            m_act = nact;
            m_cnt = (m_cnt + 1) % 256;
        end
        #1;
        if (was_valid)
            check(sys_clk == exp_ce, "R5", int'(sys_clk), int'(exp_ce), "gated clock in high phase");
        if (was_valid || !e) begin
            exp_pin = e ? int'(exp_ce) : 0;
            check(clkout_pin == exp_pin, r ? "R8" : "R7", int'(clkout_pin), exp_pin, "clock pin");
            check(clkout_ovr == e, r ? "R8" : "R7", int'(clkout_ovr), int'(e), "pin override");
        end
    endtask

    task automatic hold(input int n, input bit e);
        for (int i = 0; i < n; i++) step(0, 0, 0, e);
    endtask

    initial begin
        // R8: clock reaches the pin while reset is held
        req_tag = "R8";
        repeat (4) step(1, 0, 0, 1);
        // R1: divide by 1 right after reset
        req_tag = "R1";
        hold(8, 1);
        // R2: every legal code in turn
        req_tag = "R2";
        for (int k = 1; k <= 8; k++) begin
            step(0, 1, k, 1);
            hold(3 * (1 << k) + 260, 1);
        end
        // R4: move down from 256 and back up
        req_tag = "R4";
        step(0, 1, 1, 1);
        hold(300, 1);
        step(0, 1, 7, 1);
        hold(400, 1);
        // R3: out-of-range codes clamp to divide by 256
        req_tag = "R3";
        step(0, 1, 2, 1);
        hold(300, 1);
        step(0, 1, 15, 1);
        hold(800, 1);
        step(0, 1, 3, 1);
        hold(300, 1);
        step(0, 1, 9, 1);
        hold(800, 1);
        // R6: back-to-back writes, last one wins
        req_tag = "R6";
        step(0, 1, 1, 1);
        step(0, 1, 6, 1);
        hold(600, 1);
        // R9: rewrite the code already in force
        req_tag = "R9";
        step(0, 1, 6, 1);
        hold(400, 1);
        // R7: pin released when output disabled
        req_tag = "R7";
        hold(100, 0);
        // R4: random changes with random hold times
        req_tag = "R4";
        for (int i = 0; i < 300; i++) begin
            bit e;
            e = 1'($urandom_range(0, 1));
            step(0, 1, int'($urandom_range(0, 15)), e);
            hold(int'($urandom_range(0, 400)), e);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run completion)");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule